// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM device from a cold power-up into a state where it can accept normal traffic. After a start pulse it drives the command pins (clock enable, chip select, row strobe, column strobe, write enable), the bank address and the row address lines. It steps through a fixed ordered series of commands and raises a done flag once the device is ready. The fixed series covers the power-up hold, clock-enable release, precharge, writes to all four mode registers, the DLL reset phase, two refreshes and the output-driver calibration default and exit phases.

Every delay between commands is counted in controller clock cycles. The cycle counts are computed when the block is built, from the clock period and the device's minimum times in picoseconds, and are rounded up. One down-counter, loaded with the gap that belongs to each step, times all waits. The mode-register payloads are built from static configuration inputs: CAS latency, burst length, on-die termination selection and output drive strength. The write recovery field is derived from the clock period.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is low, and afterwards until `start` is sampled high, `ddr_cke` is low, the command pins carry NOP (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1) and `init_done` is low.
- R2: If `start` is sampled high at the edge that opens cycle s, `ddr_cke` stays low through cycle s+PWRUP_CK-1 and rises in cycle s+PWRUP_CK. Here PWRUP_CK is 200 us divided by the clock period, rounded up. Once high, `ddr_cke` stays high until reset.
- R3: A precharge-all (`cs_n`,`ras_n`,`cas_n`,`we_n` = 0,0,1,0 with `ddr_addr[10]`=1) is issued 400 ns (rounded up to cycles) after CKE rises. The next command follows at least 400 ns later, and never earlier than tRP.
- R4: Mode-register writes (pins 0,0,0,0) select their target through `ddr_ba`: 2'b10 for extended register 2, 2'b11 for extended register 3, 2'b01 for extended register 1 and 2'b00 for the main mode register.
- R5: After the first precharge-all, the commands come in this order: ext reg 2, ext reg 3, ext reg 1, main register with DLL reset, precharge-all, refresh (pins 0,0,0,1), refresh, main register without DLL reset, ext reg 1 with calibration default, ext reg 1 with calibration exit.
- R6: The main register payload has burst length in A2:A0 (3'b010 for 4, 3'b011 for 8), A3=0, CAS latency in A6:A4, A7=0 and DLL reset in A8. The DLL reset bit is set in the first write and clear in the second. A11:A9 hold the write recovery, which is tWR in cycles rounded up (at least 2), minus one.
- R7: The ext reg 1 payload has A0=0 (DLL enabled), the reduced-drive select in A1, and termination select bits in A6 (high bit) and A2 (low bit). The calibration field A9:A7 is 3'b000 in the first and last ext reg 1 writes and 3'b111 in the calibration-default write. All other bits are 0, and ext regs 2 and 3 are written with all zeros.
- R8: After each mode-register write the next command follows tMRD = 2 cycles later. After the second precharge-all the gap is tRP cycles. After each refresh the gap is tRFC cycles (105 ns rounded up, 14 cycles at 8 ns).
- R9: `init_done` rises exactly DLL_LOCK_CK = 200 cycles after the calibration-exit write. This is also at least 200 cycles after the DLL-enable write and the DLL-reset write. It stays high until reset.
- R10: Every cycle without an active command drives NOP. No command pattern other than NOP, precharge, refresh or mode-register write ever appears.
- R11: A `start` pulse while the sequence is running does not shift any command. A `start` pulse after `init_done` issues no command and leaves `init_done` high.
- R12: Reset low in the middle of the sequence returns the block at once to the R1 state. A later `start` runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins the bring-up |
| cfg_cas_lat | input | 3 | CAS latency code for the main register |
| cfg_burst8 | input | 1 | 1 selects burst length 8, 0 selects 4 |
| cfg_odt | input | 2 | Termination select, bit 1 to A6, bit 0 to A2 |
| cfg_drv_half | input | 1 | Reduced output drive strength select |
| ddr_cke | output | 1 | Clock enable to the device |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 2 | Bank address |
| ddr_addr | output | ROW_W | Row address / mode payload |
| init_done | output | 1 | Device ready for normal traffic |

## Verification
Two events can fall in the same clock edge: a `start` pulse and a wait expiring, where the sequencer moves on to its next command. The bench lines up a `start` pulse with the edge that releases the second refresh. It then judges the whole command log, with cycle stamps, against the gaps and payloads computed from the requirements. Any shift of a stamp or an extra command shows the collision was not ignored. A second collision, a `start` pulse after `init_done`, is judged by the absence of new log entries and a steady done flag.

// File: rtl/ddr2_init_pkg.sv
`timescale 1ns/1ps
// Package: ddr2_init_pkg
// Shared types and build-time helpers for the DDR2 bring-up sequencer.
// Assumes command pin order {cs_n, ras_n, cas_n, we_n} in every encoding.
package ddr2_init_pkg;

    // Command pin patterns, bit order {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } ddr_cmd_e;

    // Sequencer steps, in issue order
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWRUP,
        ST_CKE,
        ST_PRE1,
        ST_EMR2,
        ST_EMR3,
        ST_EMR1_DLL,
        ST_MRS_RST,
        ST_PRE2,
        ST_REF1,
        ST_REF2,
        ST_MRS_RUN,
        ST_EMR1_OCD,
        ST_EMR1_EXIT,
        ST_DONE
    } init_step_e;

    // Rounded-up integer division for time-to-cycle conversion
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two integers
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2_gap_timer.sv
`timescale 1ns/1ps
// Module: ddr2_gap_timer
// Single down-counter that times every inter-command gap.
// A load of N makes expire high N cycles later (N >= 1).
// Assumes load only arrives while the counter is idle.
module ddr2_gap_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;

    // Count down from the loaded value to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Last cycle of the wait
    assign expire = (cnt == CNT_W'(1));

    // R8
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (cnt == '0));

endmodule

// File: rtl/ddr2_mode_word.sv
`timescale 1ns/1ps
// Module: ddr2_mode_word
// Builds the bank address and address payload for each sequencer step.
// Assumes ROW_W >= 12 so that the write recovery field fits.
module ddr2_mode_word
    import ddr2_init_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int WR_CODE = 1
) (
    input  init_step_e       step,
    input  logic [2:0]       cfg_cas_lat,
    input  logic             cfg_burst8,
    input  logic [1:0]       cfg_odt,
    input  logic             cfg_drv_half,
    output logic [1:0]       word_ba,
    output logic [ROW_W-1:0] word_addr
);

    localparam logic [2:0] WR_FIELD = 3'(WR_CODE);

    logic [ROW_W-1:0] main_word;
    logic [ROW_W-1:0] ext1_word;
    logic             dll_rst;
    logic [2:0]       ocd_field;

    // Step-dependent bits of the main and extended-1 payloads
    always_comb begin
        dll_rst   = (step == ST_MRS_RST);
        ocd_field = (step == ST_EMR1_OCD) ? 3'b111 : 3'b000;
    end

    // Main mode register payload
    always_comb begin
        main_word        = '0;
        main_word[2:0]   = cfg_burst8 ? 3'b011 : 3'b010;
        main_word[6:4]   = cfg_cas_lat;
        main_word[8]     = dll_rst;
        main_word[11:9]  = WR_FIELD;
    end

    // Extended mode register 1 payload; A0 low keeps the DLL enabled
    always_comb begin
        ext1_word       = '0;
        ext1_word[1]    = cfg_drv_half;
        ext1_word[2]    = cfg_odt[0];
        ext1_word[6]    = cfg_odt[1];
        ext1_word[9:7]  = ocd_field;
    end

    // Select register target and payload per step
    always_comb begin
        word_ba   = 2'b00;
        word_addr = '0;
        unique case (step)
            ST_EMR2:      word_ba = 2'b10;
            ST_EMR3:      word_ba = 2'b11;
            ST_EMR1_DLL,
            ST_EMR1_OCD,
            ST_EMR1_EXIT: begin
                word_ba   = 2'b01;
                word_addr = ext1_word;
            end
            ST_MRS_RST,
            ST_MRS_RUN:   word_addr = main_word;
            ST_PRE1,
            ST_PRE2:      word_addr[10] = 1'b1;
            default:      word_addr = '0;
        endcase
    end

endmodule

// File: rtl/ddr2_cmd_drive.sv
`timescale 1ns/1ps
// Module: ddr2_cmd_drive
// Maps the current step and issue flag onto the device pins.
// Assumes issue is high for exactly one cycle per step.
module ddr2_cmd_drive
    import ddr2_init_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  init_step_e       step,
    input  logic             issue,
    input  logic [1:0]       word_ba,
    input  logic [ROW_W-1:0] word_addr,
    output logic             ddr_cke,
    output logic             ddr_cs_n,
    output logic             ddr_ras_n,
    output logic             ddr_cas_n,
    output logic             ddr_we_n,
    output logic [1:0]       ddr_ba,
    output logic [ROW_W-1:0] ddr_addr
);

    ddr_cmd_e step_cmd;
    ddr_cmd_e pin_cmd;

    // Command type that belongs to each step
    always_comb begin
        unique case (step)
            ST_PRE1, ST_PRE2:           step_cmd = CMD_PRE;
            ST_REF1, ST_REF2:           step_cmd = CMD_REF;
            ST_EMR2, ST_EMR3,
            ST_EMR1_DLL, ST_EMR1_OCD,
            ST_EMR1_EXIT,
            ST_MRS_RST, ST_MRS_RUN:     step_cmd = CMD_MRS;
            default:                    step_cmd = CMD_NOP;
        endcase
    end

    // Gate the command to the issue cycle; NOP everywhere else
    always_comb begin
        pin_cmd  = issue ? step_cmd : CMD_NOP;
        ddr_ba   = issue ? word_ba : 2'b00;
        ddr_addr = issue ? word_addr : '0;
        {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = pin_cmd;
    end

    // Clock enable stays low until the power-up hold ends
    assign ddr_cke = (step != ST_IDLE) && (step != ST_PWRUP);

endmodule

// File: rtl/ddr2_init_seq.sv
`timescale 1ns/1ps
// Module: ddr2_init_seq
// DDR2 power-up initialization sequencer. On start it walks a fixed
// command list, spacing commands by gaps computed from CLK_PERIOD_PS,
// and raises init_done after the final wait. Assumes static cfg inputs
// during the sequence and a clock period of at least 2 ns.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 8000,
    parameter int PWRUP_PS      = 200_000_000,
    parameter int CKE_SETTLE_PS = 400_000,
    parameter int TRP_PS        = 15_000,
    parameter int TRFC_PS       = 105_000,
    parameter int TWR_PS        = 15_000,
    parameter int TMRD_CK       = 2,
    parameter int DLL_LOCK_CK   = 200,
    parameter int ROW_W         = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       cfg_cas_lat,
    input  logic             cfg_burst8,
    input  logic [1:0]       cfg_odt,
    input  logic             cfg_drv_half,
    output logic             ddr_cke,
    output logic             ddr_cs_n,
    output logic             ddr_ras_n,
    output logic             ddr_cas_n,
    output logic             ddr_we_n,
    output logic [1:0]       ddr_ba,
    output logic [ROW_W-1:0] ddr_addr,
    output logic             init_done
);

    // Gaps in cycles, rounded up, never below 2 (counter scheme minimum)
    localparam int PWRUP_CK = imax(ceil_div(PWRUP_PS, CLK_PERIOD_PS), 2);
    localparam int CKE_CK   = imax(ceil_div(CKE_SETTLE_PS, CLK_PERIOD_PS), 2);
    localparam int TRP_CK   = imax(ceil_div(TRP_PS, CLK_PERIOD_PS), 2);
    localparam int TRFC_CK  = imax(ceil_div(TRFC_PS, CLK_PERIOD_PS), 2);
    localparam int MRD_CK   = imax(TMRD_CK, 2);
    localparam int PRE1_CK  = imax(CKE_CK, TRP_CK);
    localparam int FINAL_CK = imax(DLL_LOCK_CK, MRD_CK);
    localparam int WR_CODE  = imax(ceil_div(TWR_PS, CLK_PERIOD_PS), 2) - 1;
    localparam int MAX_GAP  = imax(imax(PWRUP_CK, FINAL_CK), imax(PRE1_CK, TRFC_CK));
    localparam int CNT_W    = $clog2(MAX_GAP + 1);

    init_step_e       step_q;
    logic             issue_q;
    logic             expire;
    logic [CNT_W-1:0] gap_m1;
    logic [1:0]       word_ba;
    logic [ROW_W-1:0] word_addr;

    // Successor of each step in the bring-up order
    function automatic init_step_e next_step(input init_step_e s);
        unique case (s)
            ST_PWRUP:     return ST_CKE;
            ST_CKE:       return ST_PRE1;
            ST_PRE1:      return ST_EMR2;
            ST_EMR2:      return ST_EMR3;
            ST_EMR3:      return ST_EMR1_DLL;
            ST_EMR1_DLL:  return ST_MRS_RST;
            ST_MRS_RST:   return ST_PRE2;
            ST_PRE2:      return ST_REF1;
            ST_REF1:      return ST_REF2;
            ST_REF2:      return ST_MRS_RUN;
            ST_MRS_RUN:   return ST_EMR1_OCD;
            ST_EMR1_OCD:  return ST_EMR1_EXIT;
            ST_EMR1_EXIT: return ST_DONE;
            default:      return s;
        endcase
    endfunction

    // Gap to the next command, minus one, for the current step
    always_comb begin
        unique case (step_q)
            ST_PWRUP:          gap_m1 = CNT_W'(PWRUP_CK - 1);
            ST_CKE:            gap_m1 = CNT_W'(CKE_CK - 1);
            ST_PRE1:           gap_m1 = CNT_W'(PRE1_CK - 1);
            ST_PRE2:           gap_m1 = CNT_W'(TRP_CK - 1);
            ST_REF1, ST_REF2:  gap_m1 = CNT_W'(TRFC_CK - 1);
            ST_EMR1_EXIT:      gap_m1 = CNT_W'(FINAL_CK - 1);
            default:           gap_m1 = CNT_W'(MRD_CK - 1);
        endcase
    end

    // Step sequencing: one issue cycle, then wait until the timer expires
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= ST_IDLE;
            issue_q <= 1'b0;
        end else if (step_q == ST_IDLE) begin
            if (start) begin
                step_q  <= ST_PWRUP;
                issue_q <= 1'b1;
            end
        end else if (issue_q) begin
            issue_q <= 1'b0;
        end else if (expire && step_q != ST_DONE) begin
            step_q  <= next_step(step_q);
            issue_q <= (next_step(step_q) != ST_DONE);
        end
    end

    ddr2_gap_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (issue_q),
        .load_val (gap_m1),
        .expire   (expire)
    );

    ddr2_mode_word #(
        .ROW_W   (ROW_W),
        .WR_CODE (WR_CODE)
    ) u_word (
        .step         (step_q),
        .cfg_cas_lat  (cfg_cas_lat),
        .cfg_burst8   (cfg_burst8),
        .cfg_odt      (cfg_odt),
        .cfg_drv_half (cfg_drv_half),
        .word_ba      (word_ba),
        .word_addr    (word_addr)
    );

    ddr2_cmd_drive #(
        .ROW_W (ROW_W)
    ) u_drive (
        .step      (step_q),
        .issue     (issue_q),
        .word_ba   (word_ba),
        .word_addr (word_addr),
        .ddr_cke   (ddr_cke),
        .ddr_cs_n  (ddr_cs_n),
        .ddr_ras_n (ddr_ras_n),
        .ddr_cas_n (ddr_cas_n),
        .ddr_we_n  (ddr_we_n),
        .ddr_ba    (ddr_ba),
        .ddr_addr  (ddr_addr)
    );

    // Ready flag follows the terminal step
    assign init_done = (step_q == ST_DONE);

    // R10
    wait_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_q |-> ({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'b0111));

    // R10
    cmd_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} != 4'b0111)
        |=> ({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'b0111));

    // R2
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ddr_cke |=> ddr_cke);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R3
    pre_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'b0010) |-> ddr_addr[10]);

    // R4
    mr_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'b0000) |-> ddr_cke);

endmodule

// File: tb/sim_ddr2_init_seq.sv
`timescale 1ns/1ps
// Directed bench for ddr2_init_seq: logs every command with its cycle
// stamp and compares order, bank address, payload and gaps.
module sim_ddr2_init_seq;

    localparam int E_PWR  = (200_000_000 + 7999) / 8000;
    localparam int E_CKE  = (400_000 + 7999) / 8000;
    localparam int E_TRP  = ((15_000 + 7999) / 8000 < 2) ? 2 : (15_000 + 7999) / 8000;
    localparam int E_TRFC = (105_000 + 7999) / 8000;
    localparam int E_MRD  = 2;
    localparam int E_DLL  = 200;
    localparam int E_WR   = ((15_000 + 7999) / 8000 < 2) ? 1 : (15_000 + 7999) / 8000 - 1;
    localparam int E_PRE1 = (E_CKE > E_TRP) ? E_CKE : E_TRP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cfg_cas_lat = 3'd3;
    logic        cfg_burst8 = 1'b0;
    logic [1:0]  cfg_odt = 2'b00;
    logic        cfg_drv_half = 1'b0;
    logic        ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
    logic [1:0]  ddr_ba;
    logic [12:0] ddr_addr;
    logic        init_done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    logic [3:0]  lg_cmd [0:63];
    logic [1:0]  lg_ba  [0:63];
    logic [12:0] lg_a   [0:63];
    int          lg_t   [0:63];
    int          lg_n = 0;
    int          bad_cnt = 0;
    int          done_t = 0;
    logic        cke_prev = 1'b0;
    logic        done_prev = 1'b0;

    ddr2_init_seq u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cfg_cas_lat  (cfg_cas_lat),
        .cfg_burst8   (cfg_burst8),
        .cfg_odt      (cfg_odt),
        .cfg_drv_half (cfg_drv_half),
        .ddr_cke      (ddr_cke),
        .ddr_cs_n     (ddr_cs_n),
        .ddr_ras_n    (ddr_ras_n),
        .ddr_cas_n    (ddr_cas_n),
        .ddr_we_n     (ddr_we_n),
        .ddr_ba       (ddr_ba),
        .ddr_addr     (ddr_addr),
        .init_done    (init_done)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Command monitor, sampled mid-cycle
    always @(negedge clk) begin
        logic [3:0] code;
        code = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
        if (ddr_cke === 1'b1 && cke_prev !== 1'b1 && lg_n < 64) begin
            lg_cmd[lg_n] = 4'hF; lg_ba[lg_n] = 2'b00; lg_a[lg_n] = '0;
            lg_t[lg_n] = cyc; lg_n = lg_n + 1;
        end
        cke_prev = ddr_cke;
        if (code !== 4'b0111) begin
            if ((code === 4'b0000 || code === 4'b0001 || code === 4'b0010) && lg_n < 64) begin
                lg_cmd[lg_n] = code; lg_ba[lg_n] = ddr_ba; lg_a[lg_n] = ddr_addr;
                lg_t[lg_n] = cyc; lg_n = lg_n + 1;
            end else begin
                bad_cnt = bad_cnt + 1;
            end
        end
        if (init_done === 1'b1 && done_prev !== 1'b1) done_t = cyc;
        done_prev = init_done;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_cmd(input int i);
        case (i)
            0: return 4'hF;
            1, 6: return 4'b0010;
            7, 8: return 4'b0001;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic int exp_ba(input int i);
        case (i)
            2: return 2;
            3: return 3;
            4, 10, 11: return 1;
            5, 9: return 0;
            default: return -1;
        endcase
    endfunction

    function automatic int exp_gap(input int i);
        case (i)
            0: return E_CKE;
            1: return E_PRE1;
            6: return E_TRP;
            7, 8: return E_TRFC;
            11: return E_DLL;
            default: return E_MRD;
        endcase
    endfunction

    function automatic int ext1_word(input int ocd);
        return (ocd << 7) | (int'(cfg_odt[1]) << 6) | (int'(cfg_odt[0]) << 2)
             | (int'(cfg_drv_half) << 1);
    endfunction

    function automatic int main_word(input int dll);
        return (E_WR << 9) | (dll << 8) | (int'(cfg_cas_lat) << 4) | (cfg_burst8 ? 3 : 2);
    endfunction

    function automatic int exp_addr(input int i);
        case (i)
            2, 3: return 0;
            4, 11: return ext1_word(0);
            10: return ext1_word(7);
            5: return main_word(1);
            9: return main_word(0);
            default: return -1;
        endcase
    endfunction

    // R1: reset state and idle until start
    task automatic t_reset_state();
        int base;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ddr_cke === 1'b0, "R1 cke in reset", ddr_cke, 0);
        chk({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} === 4'b0111, "R1 nop in reset",
            {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, 7);
        chk(init_done === 1'b0, "R1 done in reset", init_done, 0);
        rst_n = 1'b1;
        base = lg_n;
        repeat (100) @(negedge clk);
        chk(lg_n == base, "R1 no command before start", lg_n - base, 0);
        chk(ddr_cke === 1'b0 && init_done === 1'b0, "R1 idle after reset",
            {ddr_cke, init_done}, 0);
    endtask

    // R2-R11: full sequence, optionally with a start pulse on an advance edge
    task automatic t_full_run(input logic [2:0] cl, input logic b8, input logic [1:0] odt,
                              input logic drv, input bit inject);
        int base, s, bad0, target;
        @(negedge clk);
        cfg_cas_lat = cl; cfg_burst8 = b8; cfg_odt = odt; cfg_drv_half = drv;
        base = lg_n; bad0 = bad_cnt;
        start = 1'b1; s = cyc + 1;
        @(negedge clk); start = 1'b0;
        if (inject) begin
            // R11: start coincides with the edge that releases the second refresh
            target = s + E_PWR;
            for (int i = 0; i < 8; i++) target += exp_gap(i);
            while (cyc < target - 1) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (init_done !== 1'b1) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(lg_n - base == 12, "R5 command count", lg_n - base, 12);
        if (lg_n - base >= 12) begin
            chk(lg_t[base] - s == E_PWR, "R2 power-up hold", lg_t[base] - s, E_PWR);
            for (int i = 0; i < 12; i++) begin
                chk(lg_cmd[base+i] == exp_cmd(i), "R5 command order", lg_cmd[base+i], exp_cmd(i));
                if (exp_ba(i) >= 0)
                    chk(lg_ba[base+i] == exp_ba(i), "R4 bank select", lg_ba[base+i], exp_ba(i));
                if (i == 1 || i == 6)
                    chk(lg_a[base+i][10] == 1'b1, "R3 precharge all A10", lg_a[base+i][10], 1);
                if (i == 5 || i == 9)
                    chk(int'(lg_a[base+i]) == exp_addr(i), "R6 main payload",
                        lg_a[base+i], exp_addr(i));
                if (i == 2 || i == 3 || i == 4 || i == 10 || i == 11)
                    chk(int'(lg_a[base+i]) == exp_addr(i), "R7 ext payload",
                        lg_a[base+i], exp_addr(i));
                if (i >= 1 && i <= 2)
                    chk(lg_t[base+i] - lg_t[base+i-1] == exp_gap(i-1), "R3 settle gap",
                        lg_t[base+i] - lg_t[base+i-1], exp_gap(i-1));
                else if (i > 2)
                    chk(lg_t[base+i] - lg_t[base+i-1] == exp_gap(i-1), "R8 gap",
                        lg_t[base+i] - lg_t[base+i-1], exp_gap(i-1));
            end
            chk(done_t - lg_t[base+11] == E_DLL, "R9 done timing",
                done_t - lg_t[base+11], E_DLL);
            chk(done_t - lg_t[base+5] >= E_DLL, "R9 DLL window", done_t - lg_t[base+5], E_DLL);
        end
        chk(bad_cnt == bad0, "R10 only legal commands", bad_cnt - bad0, 0);
        // R11: start after done is ignored
        base = lg_n;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (300) @(negedge clk);
        chk(lg_n == base, "R11 start after done", lg_n - base, 0);
        chk(init_done === 1'b1, "R9 done sticky", init_done, 1);
    endtask

    // R12: reset midway returns to idle, restart works afterwards
    task automatic t_reset_midway();
        int base;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (E_PWR + E_CKE + 10) @(negedge clk);
        chk(ddr_cke === 1'b1, "R12 sequence under way", ddr_cke, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ddr_cke === 1'b0, "R12 cke after reset", ddr_cke, 0);
        chk(init_done === 1'b0, "R12 done after reset", init_done, 0);
        rst_n = 1'b1;
        base = lg_n;
        repeat (50) @(negedge clk);
        chk(lg_n == base, "R12 idle after reset", lg_n - base, 0);
        chk({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} === 4'b0111, "R12 nop idle",
            {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, 7);
    endtask

    initial begin
        t_reset_state();
        t_full_run(3'd3, 1'b0, 2'b01, 1'b0, 1'b1);
        t_reset_midway();
        t_full_run(3'd4, 1'b1, 2'b10, 1'b1, 1'b0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190_000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190_000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule